// File: doc/BRIEF.md
# GPIO Bank with Edge Interrupts

This block is a register-mapped general-purpose I/O controller for up to 64 pins. Each pin sits in one of two 32-bit register words: pins 0 to 31 use the low word and pins 32 to 63 use the word four bytes higher. Software sets which pins drive, the values they drive, and reads back the synchronized level of every pad. The output-enable and output-value registers go straight to the pad ports.

Each pin can also raise an interrupt on a single edge. A per-pin polarity bit chooses rising or falling. A detected edge latches a status bit, and software clears that bit by writing a one to it. The combined interrupt output is the OR of the status bits whose enable bit is set. The wake-up output is the OR of the status bits whose wake mask bit is set. The pin count is a parameter. Bits for pins that do not exist read as zero and cannot be written.

Top module: `gpio_edge_bank`

## Requirements
- R1: After a synchronous reset every register reads zero, and `pad_oe`, `pad_out`, `irq_o` and `wake_o` are all low.
- R2: The output-enable words (byte address 0x00 low, 0x04 high) are read/write, and bit p drives `pad_oe[p]` directly. A 1 means the pin drives and a 0 means input.
- R3: The output-value words (0x18 low, 0x1C high) are read/write, and bit p drives `pad_out[p]` directly.
- R4: The input words (0x10 low, 0x14 high) return each pad level after a two-flop synchronizer, so a pad change becomes readable two clocks later. Writes to these words have no effect.
- R5: The polarity words are at 0x48 and 0x4C. A polarity bit of 0 latches the status bit on a rising synchronized edge, and a 1 latches it on a falling one. The opposite edge is ignored. A status bit becomes visible three clocks after the pad change.
- R6: The status words are at 0x50 and 0x54. Writing 1 to a status bit clears it and writing 0 leaves it unchanged. An edge in the same cycle as the clearing write wins, so the bit stays set.
- R7: The enable words are at 0x40 and 0x44. Status bits latch even while their enable bit is clear. `irq_o` is high exactly when some pin has both its status bit and its enable bit set.
- R8: The wake mask words are at 0x58 and 0x5C. `wake_o` is high exactly when some pin has both its status bit and its wake mask bit set.
- R9: Pin p sits at bit p mod 32 of the low word (p < 32) or of the high word (p >= 32). Bits for pins at or above NUM_PINS read zero and ignore writes.
- R10: The output control words (0x20 low, 0x24 high) are per-pin read/write storage and do not affect any output.
- R11: Any other address, including an address that is not word aligned, reads zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 8 | Byte address of the register word |
| wr_en | input | 1 | Write strobe for the word at `addr` |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `addr` |
| pad_in | input | NUM_PINS | Asynchronous pad input levels |
| pad_out | output | NUM_PINS | Pad output values |
| pad_oe | output | NUM_PINS | Pad output enables, 1 = drive |
| irq_o | output | 1 | Combined interrupt request |
| wake_o | output | 1 | Wake-up request |

## Verification
Random pad toggles are mixed with random writes to every word, including unmapped and misaligned addresses. This separates rising from falling detection under both polarity settings, and it separates the low word from the high word. Directed sequences cover three cases. The first places a clearing write in the same cycle that an edge latches, to show that the set wins. The second writes all ones to the high words, to show that only pins below the pin count keep bits. The third lets an edge latch with the enable bit clear and then sets the enable, to show that status is captured independently of the enable and that only the interrupt output is gated.

// File: rtl/gpio_edge_pkg.sv
// Package for the GPIO edge bank: register word offsets and the address decode.
// Assumes byte addressing, 32-bit words, and at most two words per register.
package gpio_edge_pkg;

    localparam int unsigned BUS_AW  = 8;
    localparam int unsigned WORD_W  = 32;
    localparam int unsigned MAX_PIN = 64;

    // Base byte offsets; the high word of each register sits 4 bytes above.
    localparam logic [BUS_AW-1:0] OFF_OE   = 8'h00;
    localparam logic [BUS_AW-1:0] OFF_IN   = 8'h10;
    localparam logic [BUS_AW-1:0] OFF_OUT  = 8'h18;
    localparam logic [BUS_AW-1:0] OFF_CTL  = 8'h20;
    localparam logic [BUS_AW-1:0] OFF_IEN  = 8'h40;
    localparam logic [BUS_AW-1:0] OFF_POL  = 8'h48;
    localparam logic [BUS_AW-1:0] OFF_STAT = 8'h50;
    localparam logic [BUS_AW-1:0] OFF_WAKE = 8'h58;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_OE,
        SEL_IN,
        SEL_OUT,
        SEL_CTL,
        SEL_IEN,
        SEL_POL,
        SEL_STAT,
        SEL_WAKE
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e sel;
        logic     hi;
    } reg_dec_t;

    // Map a byte address to a register and a word half.
    function automatic reg_dec_t decode_addr(input logic [BUS_AW-1:0] a);
        reg_dec_t d;
        logic [BUS_AW-1:0] base;
        base  = {a[BUS_AW-1:3], 3'b000};
        d.hi  = a[2];
        d.sel = SEL_NONE;
        if (a[1:0] == 2'b00) begin
            case (base)
                OFF_OE:   d.sel = SEL_OE;
                OFF_IN:   d.sel = SEL_IN;
                OFF_OUT:  d.sel = SEL_OUT;
                OFF_CTL:  d.sel = SEL_CTL;
                OFF_IEN:  d.sel = SEL_IEN;
                OFF_POL:  d.sel = SEL_POL;
                OFF_STAT: d.sel = SEL_STAT;
                OFF_WAKE: d.sel = SEL_WAKE;
                default:  d.sel = SEL_NONE;
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
// Input conditioning for the GPIO edge bank.
// Passes each pad through two flops, keeps the previous synchronized level,
// and flags an edge in the direction its polarity bit selects (0 rising, 1 falling).
// Assumes pad_in is asynchronous to clk; no debounce is applied.
module gpio_in_sync #(
    parameter int unsigned NUM_PINS = 36
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pad_in,
    input  logic [NUM_PINS-1:0] pol,
    output logic [NUM_PINS-1:0] level,
    output logic [NUM_PINS-1:0] edge_hit
);

    logic [NUM_PINS-1:0] meta_q;
    logic [NUM_PINS-1:0] sync_q;
    logic [NUM_PINS-1:0] prev_q;

    // Two-stage synchronizer plus a one-clock history of the synchronized level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pad_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Per-pin edge qualification by polarity.
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_edge
        always_comb begin
            if (pol[p]) edge_hit[p] = prev_q[p] & ~sync_q[p];
            else        edge_hit[p] = sync_q[p] & ~prev_q[p];
        end
    end

    assign level = sync_q;

endmodule

// File: rtl/gpio_cfg_reg.sv
// Per-pin read/write configuration register spread over two 32-bit words.
// Pin p is written from bit p mod 32 of the word that p / 32 selects.
// Assumes NUM_PINS <= 64; only existing pins get storage.
module gpio_cfg_reg #(
    parameter int unsigned NUM_PINS = 36,
    parameter int unsigned WORD_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic [WORD_W-1:0]   wr_data,
    output logic [NUM_PINS-1:0] q
);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_bit
        localparam int unsigned WSEL = p / WORD_W;
        localparam int unsigned BPOS = p % WORD_W;
        logic wr_this;
        assign wr_this = (WSEL == 0) ? wr_lo : wr_hi;

        // Hold one pin's configuration bit.
        always_ff @(posedge clk) begin
            if (!rst_n)       q[p] <= 1'b0;
            else if (wr_this) q[p] <= wr_data[BPOS];
        end
    end

endmodule

// File: rtl/gpio_irq_status.sv
// Pending-interrupt status with write-one-to-clear.
// A set from an edge in the same cycle as a clearing write takes priority.
// Assumes set pulses are one clock wide per detected edge.
module gpio_irq_status #(
    parameter int unsigned NUM_PINS = 36,
    parameter int unsigned WORD_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] set_hit,
    input  logic                clr_lo,
    input  logic                clr_hi,
    input  logic [WORD_W-1:0]   wr_data,
    output logic [NUM_PINS-1:0] q
);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_bit
        localparam int unsigned WSEL = p / WORD_W;
        localparam int unsigned BPOS = p % WORD_W;
        logic clr_this;
        assign clr_this = ((WSEL == 0) ? clr_lo : clr_hi) & wr_data[BPOS];

        // Latch an edge, clear on a written one, set wins a collision.
        always_ff @(posedge clk) begin
            if (!rst_n)          q[p] <= 1'b0;
            else if (set_hit[p]) q[p] <= 1'b1;
            else if (clr_this)   q[p] <= 1'b0;
        end
    end

endmodule

// File: rtl/gpio_edge_bank.sv
// GPIO bank with per-pin single-edge interrupts.
// Decodes a simple register bus, holds per-pin configuration, and drives the
// pad controls, the combined interrupt and the wake-up request.
// Assumes 1 <= NUM_PINS <= 64, word-aligned accesses and a combinational read.
module gpio_edge_bank
    import gpio_edge_pkg::*;
#(
    parameter int unsigned NUM_PINS = 36
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [7:0]          addr,
    input  logic                wr_en,
    input  logic [31:0]         wr_data,
    output logic [31:0]         rd_data,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic                irq_o,
    output logic                wake_o
);

    localparam int unsigned PAD_W = 2 * WORD_W;

    reg_dec_t dec;
    logic [NUM_PINS-1:0] oe_q, out_q, ctl_q, ien_q, pol_q, wk_q, st_q;
    logic [NUM_PINS-1:0] lvl, edge_hit;

    // Address decode for the current bus cycle.
    always_comb dec = decode_addr(addr);

    gpio_in_sync #(.NUM_PINS(NUM_PINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .pol(pol_q),
        .level(lvl), .edge_hit(edge_hit)
    );

    gpio_cfg_reg #(.NUM_PINS(NUM_PINS), .WORD_W(WORD_W)) u_oe (
        .clk(clk), .rst_n(rst_n),
        .wr_lo(wr_en && dec.sel == SEL_OE && !dec.hi),
        .wr_hi(wr_en && dec.sel == SEL_OE && dec.hi),
        .wr_data(wr_data), .q(oe_q)
    );

    gpio_cfg_reg #(.NUM_PINS(NUM_PINS), .WORD_W(WORD_W)) u_out (
        .clk(clk), .rst_n(rst_n),
        .wr_lo(wr_en && dec.sel == SEL_OUT && !dec.hi),
        .wr_hi(wr_en && dec.sel == SEL_OUT && dec.hi),
        .wr_data(wr_data), .q(out_q)
    );

    gpio_cfg_reg #(.NUM_PINS(NUM_PINS), .WORD_W(WORD_W)) u_ctl (
        .clk(clk), .rst_n(rst_n),
        .wr_lo(wr_en && dec.sel == SEL_CTL && !dec.hi),
        .wr_hi(wr_en && dec.sel == SEL_CTL && dec.hi),
        .wr_data(wr_data), .q(ctl_q)
    );

    gpio_cfg_reg #(.NUM_PINS(NUM_PINS), .WORD_W(WORD_W)) u_ien (
        .clk(clk), .rst_n(rst_n),
        .wr_lo(wr_en && dec.sel == SEL_IEN && !dec.hi),
        .wr_hi(wr_en && dec.sel == SEL_IEN && dec.hi),
        .wr_data(wr_data), .q(ien_q)
    );

    gpio_cfg_reg #(.NUM_PINS(NUM_PINS), .WORD_W(WORD_W)) u_pol (
        .clk(clk), .rst_n(rst_n),
        .wr_lo(wr_en && dec.sel == SEL_POL && !dec.hi),
        .wr_hi(wr_en && dec.sel == SEL_POL && dec.hi),
        .wr_data(wr_data), .q(pol_q)
    );

    gpio_cfg_reg #(.NUM_PINS(NUM_PINS), .WORD_W(WORD_W)) u_wk (
        .clk(clk), .rst_n(rst_n),
        .wr_lo(wr_en && dec.sel == SEL_WAKE && !dec.hi),
        .wr_hi(wr_en && dec.sel == SEL_WAKE && dec.hi),
        .wr_data(wr_data), .q(wk_q)
    );

    gpio_irq_status #(.NUM_PINS(NUM_PINS), .WORD_W(WORD_W)) u_stat (
        .clk(clk), .rst_n(rst_n), .set_hit(edge_hit),
        .clr_lo(wr_en && dec.sel == SEL_STAT && !dec.hi),
        .clr_hi(wr_en && dec.sel == SEL_STAT && dec.hi),
        .wr_data(wr_data), .q(st_q)
    );

    // Read mux: pick the register, widen to two words, pick the half.
    always_comb begin
        logic [PAD_W-1:0] wide;
        case (dec.sel)
            SEL_OE:   wide = PAD_W'(oe_q);
            SEL_IN:   wide = PAD_W'(lvl);
            SEL_OUT:  wide = PAD_W'(out_q);
            SEL_CTL:  wide = PAD_W'(ctl_q);
            SEL_IEN:  wide = PAD_W'(ien_q);
            SEL_POL:  wide = PAD_W'(pol_q);
            SEL_STAT: wide = PAD_W'(st_q);
            SEL_WAKE: wide = PAD_W'(wk_q);
            default:  wide = '0;
        endcase
        rd_data = dec.hi ? wide[PAD_W-1:WORD_W] : wide[WORD_W-1:0];
    end

    assign pad_oe  = oe_q;
    assign pad_out = out_q;
    assign irq_o   = |(st_q & ien_q);
    assign wake_o  = |(st_q & wk_q);

endmodule

// File: rtl/gpio_edge_bank_chk.sv
// Checker for gpio_edge_bank, attached by bind.
// Assumes pin 0 exists (NUM_PINS >= 1).
module gpio_edge_bank_chk #(
    parameter int unsigned NUM_PINS = 36
) (
    input logic                clk,
    input logic                rst_n,
    input logic [7:0]          addr,
    input logic                wr_en,
    input logic [31:0]         wr_data,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic [NUM_PINS-1:0] pad_out,
    input logic                irq_o,
    input logic                wake_o,
    input logic [NUM_PINS-1:0] st_q,
    input logic [NUM_PINS-1:0] ien_q,
    input logic [NUM_PINS-1:0] wk_q,
    input logic [NUM_PINS-1:0] edge_hit
);

    assert_oe_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 8'h00) |=> (pad_oe[0] == $past(wr_data[0])));

    assert_out_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 8'h18) |=> (pad_out[0] == $past(wr_data[0])));

    assert_edge_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        edge_hit[0] |=> st_q[0]);

    assert_w1c_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 8'h50 && wr_data[0] && !edge_hit[0]) |=> !st_q[0]);

    assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q == '0) |-> !irq_o);

    assert_wake_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wk_q == '0) |-> !wake_o);

endmodule

bind gpio_edge_bank gpio_edge_bank_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .pad_oe(pad_oe), .pad_out(pad_out), .irq_o(irq_o), .wake_o(wake_o),
    .st_q(st_q), .ien_q(ien_q), .wk_q(wk_q), .edge_hit(edge_hit)
);

// File: tb/sim_gpio_edge_bank.sv
module sim_gpio_edge_bank;
    localparam int CLK_PERIOD = 10;
    localparam int N = 36;
    localparam logic [63:0] MASK = (N == 64) ? '1 : ((64'd1 << N) - 64'd1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] addr = '0;
    logic wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [N-1:0] pad_in = '0;
    logic [N-1:0] pad_out, pad_oe;
    logic irq_o, wake_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc_cnt = 0;

    // Expected state, kept as 64-bit pin vectors.
    logic [63:0] m_oe, m_out, m_ctl, m_ien, m_pol, m_wk, m_st, m_s1, m_s2, m_pv;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_edge_bank #(.NUM_PINS(N)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .irq_o(irq_o), .wake_o(wake_o)
    );

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 100000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    function automatic logic [31:0] half(input logic [63:0] v, input logic hi);
        return hi ? v[63:32] : v[31:0];
    endfunction

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        if (a[1:0] != 2'b00) return '0;
        case ({a[7:3], 3'b000})
            8'h00: return half(m_oe, a[2]);
            8'h10: return half(m_s2, a[2]);
            8'h18: return half(m_out, a[2]);
            8'h20: return half(m_ctl, a[2]);
            8'h40: return half(m_ien, a[2]);
            8'h48: return half(m_pol, a[2]);
            8'h50: return half(m_st, a[2]);
            8'h58: return half(m_wk, a[2]);
            default: return '0;
        endcase
    endfunction

    function automatic string req_of(input logic [7:0] a);
        if (a[1:0] != 2'b00) return "R11";
        case ({a[7:3], 3'b000})
            8'h00: return "R2";
            8'h10: return "R4";
            8'h18: return "R3";
            8'h20: return "R10";
            8'h40: return "R7";
            8'h48: return "R5";
            8'h50: return "R6";
            8'h58: return "R8";
            default: return "R11";
        endcase
    endfunction

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Advance the expected state by one clock using the inputs in force.
    task automatic model_step();
        logic [63:0] edge_v, word, wm;
        if (!rst_n) begin
            {m_oe, m_out, m_ctl, m_ien, m_pol, m_wk, m_st, m_s1, m_s2, m_pv} = '0;
            return;
        end
        edge_v = ((~m_pol & m_s2 & ~m_pv) | (m_pol & ~m_s2 & m_pv)) & MASK;
        word = addr[2] ? {wr_data, 32'h0} : {32'h0, wr_data};
        wm = (addr[2] ? {32'hFFFF_FFFF, 32'h0} : {32'h0, 32'hFFFF_FFFF}) & MASK;
        word = word & wm;
        if (wr_en && addr[1:0] == 2'b00) begin
            case ({addr[7:3], 3'b000})
                8'h00: m_oe  = (m_oe  & ~wm) | word;
                8'h18: m_out = (m_out & ~wm) | word;
                8'h20: m_ctl = (m_ctl & ~wm) | word;
                8'h40: m_ien = (m_ien & ~wm) | word;
                8'h48: m_pol = (m_pol & ~wm) | word;
                8'h58: m_wk  = (m_wk  & ~wm) | word;
                8'h50: m_st  = m_st & ~word;
                default: ;
            endcase
        end
        m_st = m_st | edge_v;
        m_pv = m_s2;
        m_s2 = m_s1;
        m_s1 = 64'(pad_in);
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        cyc();
    endtask

    task automatic rd_check(input logic [7:0] a);
        addr = a;
        #1;
        check32(req_of(a), rd_data, exp_read(a));
    endtask

    task automatic check_ports();
        #1;
        check32("R2", 32'(pad_oe[31:0]), m_oe[31:0]);
        check32("R2", 32'(pad_oe[N-1:32]), m_oe[63:32]);
        check32("R3", 32'(pad_out[31:0]), m_out[31:0]);
        check32("R3", 32'(pad_out[N-1:32]), m_out[63:32]);
        check32("R7", 32'(irq_o), 32'(|(m_st & m_ien)));
        check32("R8", 32'(wake_o), 32'(|(m_st & m_wk)));
    endtask

    logic [7:0] alist [18] = '{8'h00, 8'h04, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h20, 8'h24,
                               8'h40, 8'h44, 8'h48, 8'h4C, 8'h50, 8'h54, 8'h58, 8'h5C,
                               8'h30, 8'h52};

    initial begin
        void'($urandom(32'h5EED_0042));
        {m_oe, m_out, m_ctl, m_ien, m_pol, m_wk, m_st, m_s1, m_s2, m_pv} = '0;
        @(negedge clk);
        cyc(); cyc();
        rst_n = 1'b1;

        // R1: reset state, explicit values.
        for (int i = 0; i < 18; i++) begin
            addr = alist[i]; #1;
            check32("R1", rd_data, 32'h0);
        end
        #1;
        check32("R1", {30'h0, irq_o, wake_o}, 32'h0);
        check32("R1", 32'(pad_oe | pad_out), 32'h0);

        // R9: all-ones to high words keeps only pins below N.
        wr(8'h04, 32'hFFFF_FFFF);
        addr = 8'h04; #1; check32("R9", rd_data, 32'h0000_000F);
        wr(8'h00, 32'hA5A5_5A5A);
        check_ports();
        rd_check(8'h00);
        // R4: input words ignore writes; R11: unmapped ignores writes.
        wr(8'h10, 32'hFFFF_FFFF);
        addr = 8'h10; #1; check32("R4", rd_data, 32'h0);
        wr(8'h30, 32'hFFFF_FFFF);
        addr = 8'h30; #1; check32("R11", rd_data, 32'h0);

        // R6 priority: rising edge on pin 35 collides with a clear.
        pad_in[35] = 1'b1;
        cyc(); cyc();
        addr = 8'h14; #1; check32("R4", rd_data, 32'h0000_0008);
        wr(8'h54, 32'h0000_0008);
        addr = 8'h54; #1; check32("R6", rd_data, 32'h0000_0008);
        wr(8'h54, 32'h0000_0000);
        addr = 8'h54; #1; check32("R6", rd_data, 32'h0000_0008);
        // R7: status held while enable clear, irq follows once enabled.
        #1; check32("R7", 32'(irq_o), 32'h0);
        wr(8'h44, 32'h0000_0008);
        #1; check32("R7", 32'(irq_o), 32'h1);
        wr(8'h5C, 32'h0000_0008);
        #1; check32("R8", 32'(wake_o), 32'h1);
        wr(8'h54, 32'h0000_0008);
        addr = 8'h54; #1; check32("R6", rd_data, 32'h0);
        #1; check32("R7", 32'(irq_o), 32'h0);

        // R5: falling edge ignored under rising polarity, caught under falling.
        wr(8'h40, 32'h0000_0001);
        pad_in[0] = 1'b1; cyc(); cyc(); cyc();
        wr(8'h50, 32'h1);
        pad_in[0] = 1'b0; cyc(); cyc(); cyc(); cyc();
        addr = 8'h50; #1; check32("R5", rd_data, 32'h0);
        wr(8'h48, 32'h1);
        pad_in[0] = 1'b1; cyc(); cyc(); cyc(); cyc();
        pad_in[0] = 1'b0; cyc(); cyc();
        addr = 8'h50; #1; check32("R5", rd_data, 32'h0);
        cyc();
        addr = 8'h50; #1; check32("R5", rd_data, 32'h1);
        #1; check32("R7", 32'(irq_o), 32'h1);

        // Random phase, checked against the expected state.
        for (int it = 0; it < 4000; it++) begin
            if ($urandom_range(3) == 0) pad_in = pad_in ^ N'(64'd1 << $urandom_range(N-1));
            if ($urandom_range(2) == 0) begin
                addr = alist[$urandom_range(17)];
                wr_data = $urandom();
                wr_en = 1'b1;
            end
            cyc();
            check_ports();
            rd_check(alist[$urandom_range(17)]);
        end

        summary();
        $finish;
    end
endmodule